// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the outgoing side of a per-core interrupt controller. Software writes a 64-bit command, split into two 32-bit words at fixed offsets of the controller's register window, to send an interrupt message to other cores. The high word holds the target identifier. The low word holds the vector, the delivery kind, the addressing mode, level and trigger attributes, and a two-bit shorthand that can replace the target field with "self", "everyone" or "everyone else".

A write to the low word is the event that launches a message. The block copies the fields into a registered outgoing message and raises a valid strobe. It keeps a read-only pending bit set until the interconnect accepts the message with a valid/ready handshake. Software polls that bit through ordinary register reads. A second low-word write that arrives while a message is still outstanding is discarded, and a sticky error flag records it. A delivery-kind code that has no meaning is stored for readback, but it sends nothing.

Top module: `ipi_cmd_reg`

## Requirements
- R1: While reset is held and on the first cycle after it, msg_valid, err_drop and rd_data are all 0.
- R2: A write to byte offset 0x310 stores wr_data[31:24] as the target ID. A read of 0x310 returns that ID in bits 31:24 and 0 in every other bit.
- R3: A read of offset 0x300 returns the following layout, with every other bit 0: vector in bits 7:0, delivery kind in 10:8, addressing mode (0 physical, 1 logical) in 11, pending in 12, level in 14, trigger in 15, shorthand in 19:18.
- R4: A write to 0x300 while idle, carrying a delivery kind other than 3'b011 or 3'b111, raises msg_valid and the pending bit on the next clock edge.
- R5: msg_valid and every message field stay constant while msg_ready is low. Pending and msg_valid clear on the edge at which msg_valid and msg_ready are both high.
- R6: The shorthand resolves the target. 00 gives msg_dest = stored ID with broadcast 0 and self 0. 01 gives msg_dest = local_id with broadcast 0 and self 1. 10 gives msg_dest = 8'hFF with broadcast 1 and self 1. 11 gives msg_dest = 8'hFF with broadcast 1 and self 0.
- R7: The message carries the written vector, delivery kind, addressing mode, level and trigger, together with msg_src = local_id.
- R8: A 0x300 write that arrives while pending is 1 changes no stored field and no message field, and it sets err_drop, which then stays 1 until reset. Bit 12 of a written word never sets pending.
- R9: A 0x300 write with delivery kind 3'b011 or 3'b111 while idle stores its fields for readback but leaves pending and msg_valid at 0.
- R10: rd_data is registered and shows the result of a read one cycle after rd_en. Reads of any offset other than 0x300 or 0x310 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_id | input | 8 | This core's own identifier |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset in the register window |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| msg_valid | output | 1 | Outgoing message is valid |
| msg_ready | input | 1 | Interconnect accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_kind | output | 3 | Delivery kind code |
| msg_logical | output | 1 | Logical (1) or physical (0) addressing |
| msg_level | output | 1 | Level attribute |
| msg_trigger | output | 1 | Trigger attribute (1 = level-triggered) |
| msg_dest | output | 8 | Resolved target ID |
| msg_bcast | output | 1 | Message goes to all cores |
| msg_self | output | 1 | Sender is among the recipients |
| msg_src | output | 8 | Sender ID |
| err_drop | output | 1 | Sticky flag: a command write was dropped |

## Verification
The hardest case to reach is a command write that lands while an earlier message is still waiting on the interconnect, above all on the same edge at which the handshake completes. That write has to be dropped even though pending clears on that edge. The stimulus holds msg_ready low across several cycles, issues a second command during the stall, and in the randomized phase lets ready toggle freely while new commands arrive back to back. The bench compares each cycle against its model and so catches any write that slips through or any message field that is disturbed.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 8;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned KIND_W = 3;

  // bit positions of the command low word
  localparam int unsigned VEC_LSB  = 0;
  localparam int unsigned KIND_LSB = 8;
  localparam int unsigned LOG_BIT  = 11;
  localparam int unsigned PEND_BIT = 12;
  localparam int unsigned LVL_BIT  = 14;
  localparam int unsigned TRG_BIT  = 15;
  localparam int unsigned SH_LSB   = 18;
  localparam int unsigned DEST_LSB = 24;

  typedef enum logic [1:0] {
    SH_TARGET = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [KIND_W-1:0] kind;
    logic              logical;
    logic              level;
    logic              trigger;
    shorthand_e        sh;
  } cmd_fields_t;

  function automatic cmd_fields_t unpack_low(input logic [DATA_W-1:0] w);
    cmd_fields_t f;
    f.vector  = w[VEC_LSB +: VEC_W];
    f.kind    = w[KIND_LSB +: KIND_W];
    f.logical = w[LOG_BIT];
    f.level   = w[LVL_BIT];
    f.trigger = w[TRG_BIT];
    f.sh      = shorthand_e'(w[SH_LSB +: 2]);
    return f;
  endfunction

  function automatic logic kind_reserved(input logic [KIND_W-1:0] k);
    return (k == 3'b011) || (k == 3'b111);
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFS = 12'h310
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              lo_wr,
  output logic              hi_wr,
  output logic              lo_rd,
  output logic              hi_rd
);
  always_comb begin
    lo_wr = wr_en && (wr_addr == LO_OFS);
    hi_wr = wr_en && (wr_addr == HI_OFS);
    lo_rd = rd_en && (rd_addr == LO_OFS);
    hi_rd = rd_en && (rd_addr == HI_OFS);
  end
endmodule

// File: rtl/ipi_fields.sv
module ipi_fields
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_wr,
  input  logic              lo_accept,
  input  logic [DATA_W-1:0] wr_data,
  output cmd_fields_t       fields_q,
  output logic [ID_W-1:0]   dest_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fields_q <= '0;
      dest_q   <= '0;
    end else begin
      if (hi_wr)     dest_q   <= wr_data[DEST_LSB +: ID_W];
      if (lo_accept) fields_q <= unpack_low(wr_data);
    end
  end
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   local_id,
  input  logic              lo_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ID_W-1:0]   dest_q,
  input  logic              msg_ready,
  output logic              lo_accept,
  output logic              pending,
  output logic              err_drop,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [KIND_W-1:0] msg_kind,
  output logic              msg_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [ID_W-1:0]   msg_dest,
  output logic              msg_bcast,
  output logic              msg_self,
  output logic [ID_W-1:0]   msg_src
);
  cmd_fields_t     wf;
  logic            launch;
  logic            handshake;
  logic [ID_W-1:0] res_dest;
  logic            res_bcast;
  logic            res_self;

  always_comb begin
    wf        = unpack_low(wr_data);
    lo_accept = lo_wr && !pending;
    launch    = lo_accept && !kind_reserved(wf.kind);
    handshake = pending && msg_ready;
    unique case (wf.sh)
      SH_TARGET: begin res_dest = dest_q;   res_bcast = 1'b0; res_self = 1'b0; end
      SH_SELF:   begin res_dest = local_id; res_bcast = 1'b0; res_self = 1'b1; end
      SH_ALL:    begin res_dest = '1;       res_bcast = 1'b1; res_self = 1'b1; end
      default:   begin res_dest = '1;       res_bcast = 1'b1; res_self = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      err_drop <= 1'b0;
    end else begin
      if (launch)         pending <= 1'b1;
      else if (handshake) pending <= 1'b0;
      if (lo_wr && pending) err_drop <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_vector  <= '0;
      msg_kind    <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_trigger <= 1'b0;
      msg_dest    <= '0;
      msg_bcast   <= 1'b0;
      msg_self    <= 1'b0;
      msg_src     <= '0;
    end else if (launch) begin
      msg_vector  <= wf.vector;
      msg_kind    <= wf.kind;
      msg_logical <= wf.logical;
      msg_level   <= wf.level;
      msg_trigger <= wf.trigger;
      msg_dest    <= res_dest;
      msg_bcast   <= res_bcast;
      msg_self    <= res_self;
      msg_src     <= local_id;
    end
  end

  // R5
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !msg_ready) |=> (pending && $stable(msg_vector) && $stable(msg_dest)
                                 && $stable(msg_kind) && $stable(msg_bcast)));
  // R5
  clear_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && msg_ready) |=> !pending);
  // R8
  drop_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && pending) |=> err_drop);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_drop |=> err_drop);
  // R9
  reserved_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !pending && kind_reserved(wr_data[KIND_LSB +: KIND_W])) |=> !pending);
  // R4
  launch_raises_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !pending && !kind_reserved(wr_data[KIND_LSB +: KIND_W])) |=> pending);
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_rd,
  input  logic              hi_rd,
  input  cmd_fields_t       fields_q,
  input  logic [ID_W-1:0]   dest_q,
  input  logic              pending,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] lo_word;
  logic [DATA_W-1:0] hi_word;

  always_comb begin
    lo_word = '0;
    lo_word[VEC_LSB +: VEC_W]   = fields_q.vector;
    lo_word[KIND_LSB +: KIND_W] = fields_q.kind;
    lo_word[LOG_BIT]            = fields_q.logical;
    lo_word[PEND_BIT]           = pending;
    lo_word[LVL_BIT]            = fields_q.level;
    lo_word[TRG_BIT]            = fields_q.trigger;
    lo_word[SH_LSB +: 2]        = fields_q.sh;
    hi_word = '0;
    hi_word[DEST_LSB +: ID_W]   = dest_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (lo_rd) rd_data <= lo_word;
    else if (hi_rd) rd_data <= hi_word;
    else            rd_data <= '0;
  end

  // R2
  hi_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hi_rd |=> (rd_data[DEST_LSB-1:0] == '0));
  // R10
  stray_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!lo_rd && !hi_rd) |=> (rd_data == '0));
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFS = 12'h310
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   local_id,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [KIND_W-1:0] msg_kind,
  output logic              msg_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [ID_W-1:0]   msg_dest,
  output logic              msg_bcast,
  output logic              msg_self,
  output logic [ID_W-1:0]   msg_src,
  output logic              err_drop
);
  logic        lo_wr, hi_wr, lo_rd, hi_rd;
  logic        lo_accept;
  logic        pending;
  cmd_fields_t fields_q;
  logic [ID_W-1:0] dest_q;

  ipi_decode #(.ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .lo_rd(lo_rd), .hi_rd(hi_rd)
  );

  ipi_fields u_fields (
    .clk(clk), .rst(rst), .hi_wr(hi_wr), .lo_accept(lo_accept),
    .wr_data(wr_data), .fields_q(fields_q), .dest_q(dest_q)
  );

  ipi_launch u_launch (
    .clk(clk), .rst(rst), .local_id(local_id), .lo_wr(lo_wr), .wr_data(wr_data),
    .dest_q(dest_q), .msg_ready(msg_ready), .lo_accept(lo_accept),
    .pending(pending), .err_drop(err_drop),
    .msg_vector(msg_vector), .msg_kind(msg_kind), .msg_logical(msg_logical),
    .msg_level(msg_level), .msg_trigger(msg_trigger), .msg_dest(msg_dest),
    .msg_bcast(msg_bcast), .msg_self(msg_self), .msg_src(msg_src)
  );

  ipi_readback u_readback (
    .clk(clk), .rst(rst), .lo_rd(lo_rd), .hi_rd(hi_rd), .fields_q(fields_q),
    .dest_q(dest_q), .pending(pending), .rd_data(rd_data)
  );

  assign msg_valid = pending;

  // R6
  bcast_dest_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_bcast) |-> (msg_dest == '1));
  // R7
  src_is_local_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && $stable(local_id)) |-> (msg_src == local_id));
endmodule

// File: tb/ipi_cmd_reg_bench.sv
module ipi_cmd_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  local_id = 8'h07;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector, msg_dest, msg_src;
  logic [2:0]  msg_kind;
  logic        msg_logical, msg_level, msg_trigger, msg_bcast, msg_self, err_drop;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  ipi_cmd_reg u_ipi_cmd_reg (
    .clk(clk), .rst(rst), .local_id(local_id), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_kind(msg_kind), .msg_logical(msg_logical), .msg_level(msg_level),
    .msg_trigger(msg_trigger), .msg_dest(msg_dest), .msg_bcast(msg_bcast),
    .msg_self(msg_self), .msg_src(msg_src), .err_drop(err_drop)
  );

  // behavioural reference state
  bit [7:0]  m_vec, m_dest_reg;
  bit [2:0]  m_kind;
  bit [1:0]  m_sh;
  bit        m_log, m_lvl, m_trg, m_pend, m_err;
  bit [31:0] m_rd;
  bit [7:0]  e_vec, e_dest, e_src;
  bit [2:0]  e_kind;
  bit        e_log, e_lvl, e_trg, e_bc, e_self;

  always @(posedge clk) begin
    if (rst) begin
      m_vec = 0; m_dest_reg = 0; m_kind = 0; m_sh = 0; m_log = 0; m_lvl = 0; m_trg = 0;
      m_pend = 0; m_err = 0; m_rd = 0;
      e_vec = 0; e_dest = 0; e_src = 0; e_kind = 0; e_log = 0; e_lvl = 0; e_trg = 0;
      e_bc = 0; e_self = 0;
    end else begin
      bit [31:0] nrd;
      bit        hs;
      nrd = 0;
      if (rd_en && rd_addr == 12'h300)
        nrd = {12'b0, m_sh, 2'b0, m_trg, m_lvl, 1'b0, m_pend, m_log, m_kind, m_vec};
      else if (rd_en && rd_addr == 12'h310)
        nrd = {m_dest_reg, 24'b0};
      hs = m_pend && msg_ready;
      if (wr_en && wr_addr == 12'h310) m_dest_reg = wr_data[31:24];
      if (wr_en && wr_addr == 12'h300) begin
        if (m_pend) m_err = 1;
        else begin
          m_vec = wr_data[7:0]; m_kind = wr_data[10:8]; m_log = wr_data[11];
          m_lvl = wr_data[14]; m_trg = wr_data[15]; m_sh = wr_data[19:18];
          if (!(m_kind == 3'b011 || m_kind == 3'b111)) begin
            hs = 0;
            m_pend = 1;
            e_vec = m_vec; e_kind = m_kind; e_log = m_log; e_lvl = m_lvl; e_trg = m_trg;
            e_src = local_id;
            case (m_sh)
              2'b00: begin e_dest = m_dest_reg; e_bc = 0; e_self = 0; end
              2'b01: begin e_dest = local_id;   e_bc = 0; e_self = 1; end
              2'b10: begin e_dest = 8'hFF;      e_bc = 1; e_self = 1; end
              default: begin e_dest = 8'hFF;    e_bc = 1; e_self = 0; end
            endcase
          end
        end
      end
      if (hs) m_pend = 0;
      m_rd = nrd;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R4 R5 R9", "msg_valid", {31'b0, msg_valid}, {31'b0, m_pend});
      chk("R2 R3 R10", "rd_data", rd_data, m_rd);
      chk("R8", "err_drop", {31'b0, err_drop}, {31'b0, m_err});
      if (m_pend) begin
        chk("R6", "msg_dest", {24'b0, msg_dest}, {24'b0, e_dest});
        chk("R6", "bcast/self", {30'b0, msg_bcast, msg_self}, {30'b0, e_bc, e_self});
        chk("R7", "vector", {24'b0, msg_vector}, {24'b0, e_vec});
        chk("R7", "kind/mode/lvl/trg", {26'b0, msg_kind, msg_logical, msg_level, msg_trigger},
            {26'b0, e_kind, e_log, e_lvl, e_trg});
        chk("R7", "msg_src", {24'b0, msg_src}, {24'b0, e_src});
      end
    end
  end

  task automatic cyc(input bit we, input logic [11:0] wa, input logic [31:0] wd,
                     input bit re, input logic [11:0] ra, input bit rdy);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra; msg_ready = rdy;
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] v, input logic [2:0] k,
                                      input bit lg, input bit lv, input bit tr,
                                      input logic [1:0] sh);
    return {12'b0, sh, 2'b0, tr, lv, 1'b0, 1'b0, lg, k, v};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "reset outputs", {rd_data[0], 29'b0, msg_valid, err_drop}, 32'b0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", "after reset", {|rd_data, 29'b0, msg_valid, err_drop}, 32'b0);

    // R2: target word write and readback
    cyc(1, 12'h310, 32'h5A12_3456, 0, 0, 0);
    cyc(0, 0, 0, 1, 12'h310, 0);
    // R6 shorthand 00 with stalled interconnect (R5)
    cyc(1, 12'h300, cmd(8'h31, 3'b000, 0, 1, 0, 2'b00), 0, 0, 0);
    cyc(0, 0, 0, 1, 12'h300, 0);
    // R8: write during pending is dropped; status bit set in data
    cyc(1, 12'h300, cmd(8'h99, 3'b101, 1, 1, 1, 2'b11) | 32'h1000, 0, 0, 0);
    cyc(0, 0, 0, 1, 12'h300, 0);
    // R8: write on the same edge as the handshake is still dropped
    cyc(1, 12'h300, cmd(8'h44, 3'b000, 0, 0, 0, 2'b01), 0, 0, 1);
    cyc(0, 0, 0, 1, 12'h300, 0);
    // R6: shorthand self, all, others
    cyc(1, 12'h300, cmd(8'h11, 3'b110, 0, 1, 0, 2'b01), 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 12'h300, cmd(8'h22, 3'b100, 1, 0, 1, 2'b10), 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 12'h300, cmd(8'h33, 3'b001, 1, 1, 1, 2'b11), 0, 0, 1);
    cyc(0, 0, 0, 1, 12'h300, 1);
    // R9: reserved kinds 011 and 111 stored but not sent; bit 12 set ignored
    cyc(1, 12'h300, cmd(8'hA5, 3'b011, 1, 0, 1, 2'b00) | 32'h1000, 0, 0, 0);
    cyc(0, 0, 0, 1, 12'h300, 0);
    cyc(1, 12'h300, cmd(8'h5A, 3'b111, 0, 1, 0, 2'b10), 0, 0, 0);
    cyc(0, 0, 0, 1, 12'h300, 0);
    // R10: stray offsets read 0
    cyc(0, 0, 0, 1, 12'h320, 0);
    cyc(0, 0, 0, 1, 12'h004, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // randomized traffic
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      logic [31:0] d;
      r = $urandom % 10;
      d = $urandom;
      if (r < 4) cyc(1, 12'h300, d, $urandom % 2, ($urandom % 2) ? 12'h300 : 12'h310,
                     $urandom % 2);
      else if (r < 5) cyc(1, 12'h310, d, $urandom % 2, 12'h300, $urandom % 2);
      else cyc(0, 0, 0, $urandom % 2, ($urandom % 3 == 0) ? 12'h308 : 12'h300,
               $urandom % 2);
    end
    cyc(0, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule